// File: doc/BRIEF.md
# Freezable Branch Trail Stack

This block keeps a short history of retired taken branches as a stack of source/target word pairs. A new branch always enters at entry 0 and pushes every older record one place deeper. The deepest record falls off the end. No top-of-stack pointer exists, so software reading entry 0 always finds the most recent branch.

A performance-counter overflow can freeze the stack, so that the branches leading up to the overflow stay intact until the interrupt handler has read them. The handler reads the records through an indexed word port. It then releases the freeze with a clear strobe, and it can wipe records by writing zero words. Sign-extension bits travel with the addresses exactly as supplied. Addresses are not made canonical.

Top module: `branch_trail_stack`

## Requirements
- R1: Word index 2*i reads entry i's source word and index 2*i+1 reads entry i's target word, for i below DEPTH (default 16). Entry 0 is the newest.
- R2: The source word holds br_src (address bits [57:0], extension bits [62:58]) unchanged in bits [62:0], with the mispredict flag in bit 63.
- R3: The target word holds br_dst (address bits [57:0], extension bits [60:58]) unchanged in bits [60:0]. Bit 61 is 0, bit 62 is the speculative flag and bit 63 is the valid flag. The valid flag is 1 for every recorded branch.
- R4: A recorded branch writes entry 0 and moves each entry i to i+1 on the next clock. The record in entry DEPTH-1 is discarded.
- R5: While rec_en is 0, branch strobes leave every entry unchanged.
- R6: An overflow pulse while frz_en is 1 raises frozen on the next clock. While frozen is 1, branch strobes leave every entry unchanged.
- R7: An overflow pulse while frz_en is 0 leaves frozen at 0, and recording continues.
- R8: A branch strobe in the same cycle as a freezing overflow is still recorded. The freeze applies from the following cycle.
- R9: frz_clr drops frozen on the next clock. If a freezing overflow arrives in the same cycle, frozen stays 1.
- R10: A write stores the full 64-bit word at its index on the next clock, whether or not the stack is frozen. Writing zero to a target word makes that entry read as not valid. If a write and a recorded branch share a cycle, the shift happens first and the written word then lands at its index.
- R11: A read of index 2*DEPTH or above returns zero, and a write there changes nothing.
- R12: After reset every word reads zero and frozen is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_en | input | 1 | Recording enable |
| frz_en | input | 1 | Freeze-on-overflow enable |
| br_vld | input | 1 | Branch retire strobe |
| br_src | input | 63 | Source address with extension bits |
| br_dst | input | 61 | Target address with extension bits |
| br_mispred | input | 1 | Branch was mispredicted |
| br_spec | input | 1 | Branch was speculative |
| ovf_pulse | input | 1 | Counter overflow pulse |
| frz_clr | input | 1 | Freeze release strobe |
| reg_idx | input | REG_IDX_W | Word index for read and write |
| reg_we | input | 1 | Word write strobe |
| reg_wdata | input | 64 | Word write data |
| reg_rdata | output | 64 | Word at reg_idx (combinational) |
| frozen | output | 1 | Freeze status |

## Verification
The assertions on a held stack assume the port inputs are never X once reset is released. The stable-stack checks exempt cycles with a write. The bench drives every input to a defined level at each falling edge and keeps reg_we at 0 except in its directed write cases, so the held-stack properties are exercised across long idle and frozen stretches. The bench uses overflow and clear pulses one cycle wide, as the freeze control expects. It also drives them together on purpose to reach the priority case.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned SRC_W  = 63;
    localparam int unsigned DST_W  = 61;

    typedef struct packed {
        logic [WORD_W-1:0] tgt;
        logic [WORD_W-1:0] src;
    } bts_rec_t;

    // source word: bit 63 mispredict, [62:0] address as supplied
    function automatic logic [WORD_W-1:0] pack_src(input logic [SRC_W-1:0] a,
                                                   input logic mp);
        return {mp, a};
    endfunction

    // target word: bit 63 valid, 62 speculative, 61 reserved zero, [60:0] address
    function automatic logic [WORD_W-1:0] pack_tgt(input logic [DST_W-1:0] a,
                                                   input logic sp);
        return {1'b1, sp, 1'b0, a};
    endfunction

endpackage

// File: rtl/bts_freeze_ctl.sv
module bts_freeze_ctl (
    input  logic clk,
    input  logic rst,
    input  logic rec_en,
    input  logic frz_en,
    input  logic br_vld,
    input  logic ovf_pulse,
    input  logic frz_clr,
    output logic push,
    output logic frozen
);
    logic frz_q;
    logic frz_set;

    assign frz_set = ovf_pulse && frz_en;
    assign push    = br_vld && rec_en && !frz_q;
    assign frozen  = frz_q;

    always_ff @(posedge clk) begin
        if (rst)          frz_q <= 1'b0;
        else if (frz_set) frz_q <= 1'b1;
        else if (frz_clr) frz_q <= 1'b0;
    end

    AST_FREEZE_SET: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && frz_en) |=> frozen); // R6
    AST_FREEZE_REL: assert property (@(posedge clk) disable iff (rst)
        (frz_clr && !(ovf_pulse && frz_en)) |=> !frozen); // R9
    AST_NO_FREEZE_OFF: assert property (@(posedge clk) disable iff (rst)
        (!frozen && !(ovf_pulse && frz_en)) |=> !frozen); // R7
endmodule

// File: rtl/bts_store.sv
module bts_store
    import bts_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  bts_rec_t                 push_rec,
    input  logic                     wr_en,
    input  logic [ENT_W-1:0]         wr_ent,
    input  logic                     wr_hi,
    input  logic [WORD_W-1:0]        wr_data,
    output bts_rec_t [DEPTH-1:0]     recs
);
    bts_rec_t [DEPTH-1:0] nxt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        bts_rec_t shifted;
        if (g == 0) begin : g_head
            assign shifted = push ? push_rec : recs[0];
        end else begin : g_body
            assign shifted = push ? recs[g-1] : recs[g];
        end

        always_comb begin
            nxt[g] = shifted;
            if (wr_en && (wr_ent == ENT_W'(g))) begin
                if (wr_hi) nxt[g].tgt = wr_data;
                else       nxt[g].src = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) recs[g] <= '0;
            else     recs[g] <= nxt[g];
        end
    end

    AST_HEAD_VALID: assert property (@(posedge clk) disable iff (rst)
        (push && !wr_en) |=> recs[0].tgt[63]); // R3
    AST_HEAD_RSVD: assert property (@(posedge clk) disable iff (rst)
        (push && !wr_en) |=> !recs[0].tgt[61]); // R3
endmodule

// File: rtl/bts_regmap.sv
module bts_regmap
    import bts_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned REG_IDX_W = 6,
    localparam int unsigned ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [REG_IDX_W-1:0]     reg_idx,
    input  logic                     reg_we,
    input  bts_rec_t [DEPTH-1:0]     recs,
    output logic [WORD_W-1:0]        reg_rdata,
    output logic                     wr_en,
    output logic [ENT_W-1:0]         wr_ent,
    output logic                     wr_hi
);
    localparam logic [REG_IDX_W:0] WORD_LIM = (REG_IDX_W+1)'(2*DEPTH);

    logic               in_range;
    logic [ENT_W-1:0]   ent;

    assign in_range = {1'b0, reg_idx} < WORD_LIM;
    assign ent      = ENT_W'(reg_idx >> 1);
    assign wr_hi    = reg_idx[0];
    assign wr_ent   = ent;
    assign wr_en    = reg_we && in_range;

    always_comb begin
        reg_rdata = '0;
        if (in_range) reg_rdata = wr_hi ? recs[ent].tgt : recs[ent].src;
    end
endmodule

// File: rtl/branch_trail_stack.sv
module branch_trail_stack
    import bts_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned REG_IDX_W = 6,
    localparam int unsigned ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rec_en,
    input  logic                 frz_en,
    input  logic                 br_vld,
    input  logic [62:0]          br_src,
    input  logic [60:0]          br_dst,
    input  logic                 br_mispred,
    input  logic                 br_spec,
    input  logic                 ovf_pulse,
    input  logic                 frz_clr,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic                 reg_we,
    input  logic [63:0]          reg_wdata,
    output logic [63:0]          reg_rdata,
    output logic                 frozen
);
    localparam logic [REG_IDX_W:0] WORD_LIM = (REG_IDX_W+1)'(2*DEPTH);

    logic                  push;
    bts_rec_t              push_rec;
    bts_rec_t [DEPTH-1:0]  recs;
    logic                  wr_en;
    logic [ENT_W-1:0]      wr_ent;
    logic                  wr_hi;

    assign push_rec.src = pack_src(br_src, br_mispred);
    assign push_rec.tgt = pack_tgt(br_dst, br_spec);

    bts_freeze_ctl u_frz (
        .clk(clk), .rst(rst), .rec_en(rec_en), .frz_en(frz_en),
        .br_vld(br_vld), .ovf_pulse(ovf_pulse), .frz_clr(frz_clr),
        .push(push), .frozen(frozen)
    );

    bts_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_rec(push_rec),
        .wr_en(wr_en), .wr_ent(wr_ent), .wr_hi(wr_hi), .wr_data(reg_wdata),
        .recs(recs)
    );

    bts_regmap #(.DEPTH(DEPTH), .REG_IDX_W(REG_IDX_W)) u_map (
        .reg_idx(reg_idx), .reg_we(reg_we), .recs(recs),
        .reg_rdata(reg_rdata), .wr_en(wr_en), .wr_ent(wr_ent), .wr_hi(wr_hi)
    );

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frozen && !reg_we) |=> $stable(recs)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rec_en && !reg_we) |=> $stable(recs)); // R5
    AST_OOR_READ: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, reg_idx} >= WORD_LIM) |-> (reg_rdata == '0)); // R11
    AST_OOR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && ({1'b0, reg_idx} >= WORD_LIM) && !push) |=> $stable(recs)); // R11
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!frozen && (recs == '0))); // R12
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (br_vld && rec_en && !frozen && ovf_pulse && frz_en && !reg_we)
        |=> (frozen && recs[0].tgt[63])); // R8
endmodule

// File: tb/branch_trail_stack_tb.sv
module branch_trail_stack_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int IDX_W      = 6;
    localparam int NVEC       = 6;

    localparam logic [62:0] VSRC [NVEC] = '{
        63'h0000_0000_0040_1000, 63'h7C00_0000_DEAD_BEEF, 63'h03FF_FFFF_FFFF_FFFF,
        63'h0000_0000_0000_0004, 63'h4400_1234_5678_9ABC, 63'h0000_0FFF_0000_0001};
    localparam logic [60:0] VDST [NVEC] = '{
        61'h0000_0000_0040_2000, 61'h1C00_0000_CAFE_F00D, 61'h03FF_FFFF_FFFF_FFFF,
        61'h0000_0000_0000_0008, 61'h1000_4321_8765_0000, 61'h0000_0000_0FFF_0002};
    localparam logic [1:0] VFLG [NVEC] = '{2'b00, 2'b10, 2'b01, 2'b11, 2'b10, 2'b00};

    logic clk = 0, rst = 1;
    logic rec_en = 0, frz_en = 0, br_vld = 0, br_mispred = 0, br_spec = 0;
    logic ovf_pulse = 0, frz_clr = 0, reg_we = 0;
    logic [62:0] br_src = '0;
    logic [60:0] br_dst = '0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic frozen;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [63:0] ef [DEPTH];
    logic [63:0] et [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_trail_stack #(.DEPTH(DEPTH), .REG_IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .rec_en(rec_en), .frz_en(frz_en), .br_vld(br_vld),
        .br_src(br_src), .br_dst(br_dst), .br_mispred(br_mispred), .br_spec(br_spec),
        .ovf_pulse(ovf_pulse), .frz_clr(frz_clr), .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frozen(frozen)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [62:0] s, input logic [60:0] d,
                              input logic mp, input logic sp);
        for (int i = DEPTH-1; i > 0; i--) begin ef[i] = ef[i-1]; et[i] = et[i-1]; end
        ef[0] = {mp, s};
        et[0] = {1'b1, sp, 1'b0, d};
    endtask

    // read at falling edge region; reg_rdata is combinational
    task automatic read_word(input int idx, output logic [63:0] v);
        reg_idx = IDX_W'(idx);
        #1 v = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [63:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            read_word(2*i, v);   chk(v, ef[i], req);
            read_word(2*i+1, v); chk(v, et[i], req);
        end
    endtask

    // one cycle of stimulus driven at negedge; state settled at next negedge
    task automatic cycle(input logic bv, input logic [62:0] s, input logic [60:0] d,
                         input logic mp, input logic sp, input logic ov, input logic cl,
                         input logic we, input int widx, input logic [63:0] wd);
        br_vld = bv; br_src = s; br_dst = d; br_mispred = mp; br_spec = sp;
        ovf_pulse = ov; frz_clr = cl; reg_we = we; reg_idx = IDX_W'(widx); reg_wdata = wd;
        @(negedge clk);
        br_vld = 0; ovf_pulse = 0; frz_clr = 0; reg_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        for (int i = 0; i < DEPTH; i++) begin ef[i] = '0; et[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset state
        check_all("R12");
        chk({63'd0, frozen}, 64'd0, "R12");

        // R1 R2 R3 R4: table walk
        rec_en = 1; frz_en = 1;
        for (int k = 0; k < NVEC; k++) begin
            cycle(1, VSRC[k], VDST[k], VFLG[k][1], VFLG[k][0], 0, 0, 0, 0, '0);
            model_push(VSRC[k], VDST[k], VFLG[k][1], VFLG[k][0]);
            check_all("R1_R2_R3_R4");
        end

        // R4: overfill, oldest discarded
        for (int k = 0; k < DEPTH + 3; k++) begin
            cycle(1, 63'(k * 64'h111) | 63'h100, 61'(k * 64'h222), k[0], k[1], 0, 0, 0, 0, '0);
            model_push(63'(k * 64'h111) | 63'h100, 61'(k * 64'h222), k[0], k[1]);
        end
        check_all("R4");

        // R5: recording disabled
        rec_en = 0;
        cycle(1, 63'h5555, 61'h6666, 1, 1, 0, 0, 0, 0, '0);
        check_all("R5");
        rec_en = 1;

        // R7: overflow without freeze enable
        frz_en = 0;
        cycle(0, '0, '0, 0, 0, 1, 0, 0, 0, '0);
        chk({63'd0, frozen}, 64'd0, "R7");
        cycle(1, 63'hA1, 61'hB1, 0, 0, 0, 0, 0, 0, '0);
        model_push(63'hA1, 61'hB1, 0, 0);
        check_all("R7");
        frz_en = 1;

        // R8: branch with overflow in same cycle
        cycle(1, 63'hA2, 61'hB2, 1, 0, 1, 0, 0, 0, '0);
        model_push(63'hA2, 61'hB2, 1, 0);
        chk({63'd0, frozen}, 64'd1, "R8");
        check_all("R8");

        // R6: frozen ignores branches
        cycle(1, 63'hA3, 61'hB3, 0, 1, 0, 0, 0, 0, '0);
        cycle(1, 63'hA4, 61'hB4, 0, 1, 0, 0, 0, 0, '0);
        check_all("R6");
        chk({63'd0, frozen}, 64'd1, "R6");

        // R9: overflow wins over clear, then clear alone
        cycle(0, '0, '0, 0, 0, 1, 1, 0, 0, '0);
        chk({63'd0, frozen}, 64'd1, "R9");
        cycle(0, '0, '0, 0, 0, 0, 1, 0, 0, '0);
        chk({63'd0, frozen}, 64'd0, "R9");
        cycle(1, 63'hA5, 61'hB5, 0, 0, 0, 0, 0, 0, '0);
        model_push(63'hA5, 61'hB5, 0, 0);
        check_all("R9");

        // R10: write zero to target word of entry 1 clears valid
        cycle(0, '0, '0, 0, 0, 0, 0, 1, 3, '0);
        et[1] = '0;
        read_word(3, v); chk({63'd0, v[63]}, 64'd0, "R10");
        // R10: write during freeze
        cycle(0, '0, '0, 0, 0, 1, 0, 0, 0, '0);
        cycle(0, '0, '0, 0, 0, 0, 0, 1, 4, 64'h0123_4567_89AB_CDEF);
        ef[2] = 64'h0123_4567_89AB_CDEF;
        check_all("R10");
        cycle(0, '0, '0, 0, 0, 0, 1, 0, 0, '0);
        // R10: write and branch in same cycle, write lands after shift
        cycle(1, 63'hA6, 61'hB6, 1, 1, 0, 0, 1, 1, 64'hFEED_0000_0000_0001);
        model_push(63'hA6, 61'hB6, 1, 1);
        et[0] = 64'hFEED_0000_0000_0001;
        check_all("R10");

        // R11: out of range
        cycle(0, '0, '0, 0, 0, 0, 0, 1, 2*DEPTH, 64'hFFFF_FFFF_FFFF_FFFF);
        read_word(2*DEPTH, v);     chk(v, 64'd0, "R11");
        read_word(2*DEPTH + 7, v); chk(v, 64'd0, "R11");
        check_all("R11");

        // R12: reset after activity
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < DEPTH; i++) begin ef[i] = '0; et[i] = '0; end
        check_all("R12");
        chk({63'd0, frozen}, 64'd0, "R12");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule